// File: doc/BRIEF.md
# Normalizing Shift-Subtract Integer Divider

This block divides an unsigned 24-bit dividend by an unsigned 13-bit divisor and returns the low 13 bits of the integer quotient. A one-cycle `start` pulse captures both operands. The block then works through two phases before raising `done`.

In the first phase the divisor is doubled, one step per cycle, until it is strictly larger than the dividend, and the doublings are counted. In the second phase the working dividend is first doubled once. Then one restoring compare-subtract is made per counted doubling, and each one shifts one quotient bit in from the right. The run length therefore follows the number of significant quotient bits, not a fixed width.

A zero divisor is caught at `start` and answered at once with an all-ones quotient. The result and `done` stay put until the next accepted `start`.

Top module: `norm_divider`

## Requirements
- R1: When `done` is high, `quotient` equals floor(dividend / divisor) modulo 2^13 for the operands captured at the accepted start. Both values then hold steady until the next accepted start.
- R2: For a non-zero divisor, let n be the smallest count for which divisor·2^n exceeds the dividend. `done` rises after the (2n+1)-th rising edge that follows the edge that accepted `start`.
- R3: A dividend smaller than the divisor (n = 0, including a zero dividend) gives quotient 0 with `done` after the first edge following acceptance.
- R4: A zero divisor gives quotient 13'h1FFF. `done` is already high right after the accepting edge, and no alignment phase is entered.
- R5: `done` is low during the whole computation of a non-zero divisor. It drops on the edge that accepts a new `start`.
- R6: A `start` pulse that arrives while a computation is in progress is ignored. The running result and its latency are unchanged.
- R7: Changes on `dividend` and `divisor` after the accepting edge have no effect on the running computation.
- R8: Synchronous active-high reset clears `done` and `quotient` to 0 and aborts any computation in progress.
- R9: The largest alignment (divisor 1, dividend at or above 2^23) completes 24 doublings without the shifted divisor overflowing the working width. For dividend 24'h800000 it gives quotient 0 after 49 edges.
- R10: During the quotient phase the working remainder stays below twice the aligned divisor, and the aligned divisor does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that captures the operands and begins a division when idle |
| dividend | input | 24 | Unsigned dividend |
| divisor | input | 13 | Unsigned divisor |
| quotient | output | 13 | Low 13 bits of the integer quotient |
| done | output | 1 | Result valid; held until the next accepted start |

## Verification
The state that is hardest to reach from the ports is the longest alignment. It needs divisor 1 and a dividend with bit 23 set, so the shift counter goes to 24 and the shifted divisor reaches its top significant bit. It also leaves the quotient wider than 13 bits, so it exercises the modulo truncation. The stimulus table holds such operands next to mid-range and equal-operand cases, and the bench measures the latency of each run against 2n+1. A second `start` and fresh operand values are then driven in the middle of a long run, to show that neither reaches the result in progress.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

    localparam int DEF_DVD_W = 24;
    localparam int DEF_DVR_W = 13;
    localparam int DEF_QUO_W = 13;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ALIGN = 2'd1,
        PH_QUOT  = 2'd2
    } phase_t;

    // Per-cycle datapath commands issued by the sequencer
    typedef struct packed {
        logic load;       // capture operands, clear quotient
        logic load_zero;  // zero divisor: force all-ones quotient
        logic shift_dsr;  // alignment: double the divisor
        logic pre_shift;  // alignment end: double the remainder once
        logic step;       // quotient phase: one compare-subtract
    } ctl_t;

    function automatic int shift_cnt_width(input int dvd_w);
        return $clog2(dvd_w + 1);
    endfunction

endpackage

// File: rtl/ndiv_sub.sv
module ndiv_sub #(
    parameter int W = 26
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic         ge,
    output logic [W-1:0] diff
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, minuend} - {1'b0, subtrahend};
        ge   = ~full[W];
        diff = full[W-1:0];
    end
endmodule

// File: rtl/ndiv_ctrl.sv
module ndiv_ctrl
    import ndiv_pkg::*;
#(
    parameter int DVD_W = 24,
    parameter int CNT_W = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   dvr_zero,
    input  logic   rem_ge_dsr,
    output ctl_t   ctl,
    output phase_t phase,
    output logic   done
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        ctl = '0;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    ctl.load_zero = dvr_zero;
                    ctl.load      = ~dvr_zero;
                end
            end
            PH_ALIGN: begin
                ctl.shift_dsr = rem_ge_dsr;
                ctl.pre_shift = ~rem_ge_dsr;
            end
            PH_QUOT:  ctl.step = 1'b1;
            default:  ctl = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (dvr_zero) begin
                            done <= 1'b1;
                        end else begin
                            done  <= 1'b0;
                            cnt   <= '0;
                            phase <= PH_ALIGN;
                        end
                    end
                end
                PH_ALIGN: begin
                    if (rem_ge_dsr) begin
                        cnt <= cnt + CNT_ONE;
                    end else if (cnt == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        phase <= PH_QUOT;
                    end
                end
                PH_QUOT: begin
                    cnt <= cnt - CNT_ONE;
                    if (cnt == CNT_ONE) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_busy_no_done_R5: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> !done);

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) <= DVD_W));

    assert_zero_div_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start && dvr_zero) |=> (done && phase == PH_IDLE));

    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_QUOT && cnt != CNT_ONE && start) |=> (phase == PH_QUOT));
endmodule

// File: rtl/ndiv_path.sv
module ndiv_path
    import ndiv_pkg::*;
#(
    parameter int DVD_W  = 24,
    parameter int DVR_W  = 13,
    parameter int QUO_W  = 13,
    parameter int WORK_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  phase_t           phase,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVR_W-1:0] divisor,
    output logic             rem_ge_dsr,
    output logic             dvr_zero,
    output logic [QUO_W-1:0] quotient
);
    logic [WORK_W-1:0] rem;
    logic [WORK_W-1:0] dsr;
    logic [WORK_W-1:0] diff;
    logic [QUO_W-1:0]  quo;

    ndiv_sub #(.W(WORK_W)) u_sub (
        .minuend    (rem),
        .subtrahend (dsr),
        .ge         (rem_ge_dsr),
        .diff       (diff)
    );

    assign dvr_zero = (divisor == '0);
    assign quotient = quo;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            dsr <= '0;
            quo <= '0;
        end else if (ctl.load) begin
            rem <= WORK_W'(dividend);
            dsr <= WORK_W'(divisor);
            quo <= '0;
        end else if (ctl.load_zero) begin
            quo <= '1;
        end else if (ctl.shift_dsr) begin
            dsr <= dsr << 1;
        end else if (ctl.pre_shift) begin
            rem <= rem << 1;
        end else if (ctl.step) begin
            if (rem_ge_dsr) begin
                rem <= diff << 1;
                quo <= {quo[QUO_W-2:0], 1'b1};
            end else begin
                rem <= rem << 1;
                quo <= {quo[QUO_W-2:0], 1'b0};
            end
        end
    end

    assert_rem_below_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_QUOT) |-> ({1'b0, rem} < {dsr, 1'b0}));

    assert_dsr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_QUOT) |=> $stable(dsr));

    assert_zero_quo_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.load_zero |=> (&quo));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ALIGN) |-> !dsr[WORK_W-1]);
endmodule

// File: rtl/norm_divider.sv
module norm_divider
    import ndiv_pkg::*;
#(
    parameter int DVD_W = DEF_DVD_W,
    parameter int DVR_W = DEF_DVR_W,
    parameter int QUO_W = DEF_QUO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVR_W-1:0] divisor,
    output logic [QUO_W-1:0] quotient,
    output logic             done
);
    // Two spare bits: aligned divisor < 2*dividend, remainder doubled once more
    localparam int WORK_W = DVD_W + 2;
    localparam int CNT_W  = shift_cnt_width(DVD_W);

    ctl_t   ctl;
    phase_t phase;
    logic   rem_ge_dsr;
    logic   dvr_zero;

    ndiv_ctrl #(.DVD_W(DVD_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dvr_zero   (dvr_zero),
        .rem_ge_dsr (rem_ge_dsr),
        .ctl        (ctl),
        .phase      (phase),
        .done       (done)
    );

    ndiv_path #(.DVD_W(DVD_W), .DVR_W(DVR_W), .QUO_W(QUO_W), .WORK_W(WORK_W)) u_path (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .phase      (phase),
        .dividend   (dividend),
        .divisor    (divisor),
        .rem_ge_dsr (rem_ge_dsr),
        .dvr_zero   (dvr_zero),
        .quotient   (quotient)
    );

    assert_done_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(quotient)));
endmodule

// File: tb/norm_divider_tb.sv
module norm_divider_tb;
    localparam int NVEC = 12;
    localparam logic [23:0] VEC_A [NVEC] = '{
        24'd100, 24'd0, 24'd4, 24'd5, 24'hFFFFFF, 24'h800000,
        24'hFFFFFF, 24'd12345, 24'd1000000, 24'hABCDEF, 24'd7, 24'd8191
    };
    localparam logic [12:0] VEC_D [NVEC] = '{
        13'd7, 13'd5, 13'd5, 13'd5, 13'd1, 13'd1,
        13'h1FFF, 13'd1, 13'd123, 13'h0F0F, 13'd8, 13'd4096
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] dividend = '0;
    logic [12:0] divisor = '0;
    logic [12:0] quotient;
    logic        done;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    norm_divider u_dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .quotient (quotient),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_shifts(input logic [23:0] a, input logic [12:0] d);
        int n = 0;
        while ((longint'(d) << n) <= longint'(a)) n++;
        return n;
    endfunction

    function automatic logic [12:0] exp_quo(input logic [23:0] a, input logic [12:0] d);
        if (d == '0) return 13'h1FFF;
        return 13'((int'(a) / int'(d)) & 'h1FFF);
    endfunction

    // Wait for done; k = edges after the accepting edge
    task automatic wait_done(output int k);
        k = 0;
        while (!done && k < 300) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_div(input logic [23:0] a, input logic [12:0] d, input string req);
        int k;
        int exp_k;
        @(negedge clk);
        dividend = a;
        divisor  = d;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(k);
        exp_k = (d == '0) ? 0 : 2 * exp_shifts(a, d) + 1;
        check(k == exp_k, {req, " latency R2"}, k, exp_k);
        check(quotient == exp_quo(a, d), {req, " quotient R1"}, quotient, exp_quo(a, d));
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(done == 1'b0, "R8 done after reset", done, 0);
        check(quotient == '0, "R8 quotient after reset", quotient, 0);

        // R1/R2: table walk
        for (int i = 0; i < NVEC; i++) begin
            run_div(VEC_A[i], VEC_D[i], "R1 table");
        end

        // R3: dividend below divisor
        run_div(24'd12, 13'd13, "R3 small");
        run_div(24'd0, 13'd1, "R3 zero dividend");

        // R4: zero divisor
        run_div(24'd999, 13'd0, "R4 zero divisor");
        run_div(24'd0, 13'd0, "R4 zero over zero");

        // R9: deepest alignment
        run_div(24'h800000, 13'd1, "R9 max align");
        check(quotient == 13'd0, "R9 wrapped quotient", quotient, 0);

        // R1: result held while idle
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R1 done held", done, 1);
        check(quotient == 13'd0, "R1 quotient held", quotient, 0);

        // R5: done drops on accepted start, R6 busy start, R7 operand change
        @(negedge clk);
        dividend = 24'd50000;
        divisor  = 13'd3;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R5 done cleared by start", done, 0);
        dividend = 24'd9;
        divisor  = 13'd9;
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R5 done low while busy", done, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 26;
        while (!done && k < 300) begin
            @(negedge clk);
            k++;
        end
        check(k == 31, "R6 busy start latency", k, 31);
        check(quotient == 13'd282, "R6 R7 quotient of first operands", quotient, 282);

        // R8: reset aborts a run
        @(negedge clk);
        dividend = 24'hFFFFFF;
        divisor  = 13'd1;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (50) @(negedge clk);
        check(done == 1'b0, "R8 done after mid-run reset", done, 0);
        check(quotient == '0, "R8 quotient after mid-run reset", quotient, 0);
        run_div(24'd1000, 13'd10, "R8 run after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule